// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block drives the two gate enables of a half-bridge power stage, plus an enable for the charge path of the high-side bootstrap capacitor. It alternates the low-side and high-side enables with equal on-times. A programmable dead interval separates them, so that the two switches are never on together. The whole switching period is set in clock cycles: a half-period count and a dead-time count. At 100 MHz, the usual dead settings of 1.1 us and 0.6 us become 110 and 60 cycles.

Switching is allowed only while a digital supply-level code is healthy. The block compares that code against a turn-on level and a lower turn-off level, so the lockout has hysteresis. An external shutdown request stops switching while it is held. It does not latch: switching resumes by itself once the request is released. Each time switching starts, the block first waits a ramp interval, and the first gate pulse is always on the low side. That first pulse charges the bootstrap capacitor before the high side is driven.

All pins are plain level signals. Nothing flows as a stream, so there is no handshake at the edge of the block.

Top module: `hb_sequencer`

## Requirements
- R1: Out of reset, and whenever the supply is in lockout, `lo_gate`, `hi_gate` and `boot_en` are all 0.
- R2: Lockout ends one clock after `supply_code` is strictly above ON_LEVEL (default 110). It starts again one clock after the code is strictly below OFF_LEVEL (default 90). A code between the two levels, or equal to either of them, leaves the current state unchanged.
- R3: After every start, the first gate pulse is on the low side. It rises after 1 + R + D low cycles counted from the cycle in which switching was enabled, where R is the ramp length and D is the clamped dead time.
- R4: In steady switching the order repeats: low side high for H−D cycles, both low for D cycles, high side high for H−D cycles, both low for D cycles. H is the clamped half-period.
- R5: `lo_gate` and `hi_gate` are never 1 in the same cycle. Either one rises only after the other has been low for at least one cycle.
- R6: `boot_en` is 1 exactly in the cycles where `lo_gate` is 1.
- R7: While `shutdown_req` is 1, all outputs are 0 from the next clock on. On release, switching restarts from the ramp without any other action, and the low side pulses first.
- R8: `half_period` and `dead_time` are captured only while the block is idle (lockout or shutdown). Changes made during switching have no effect until the next start.
- R9: A half-period below 2 is treated as 2. A dead time of 0 is treated as 1. A dead time of H or more is treated as H−1.
- R10: Dead-time counts of 110 and 60 cycles give exactly those dead intervals, for example with H = 500.
- R11: The ramp before the first dead interval lasts R = floor(H/2) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_code | input | SUPW (8) | Digital supply level |
| shutdown_req | input | 1 | Non-latched stop request, active high |
| half_period | input | CW (12) | Half of the switching period, in cycles |
| dead_time | input | CW (12) | Dead interval, in cycles |
| lo_gate | output | 1 | Low-side gate enable |
| hi_gate | output | 1 | High-side gate enable |
| boot_en | output | 1 | Bootstrap charge enable |

## Verification
The phase register and its down-counter set every edge of the outputs. A wrong phase or a wrong counter load therefore appears at the ports within one half-period. It shows as a pulse of the wrong width, a dead gap of the wrong length, or a high-side pulse with no low-side pulse before it after a start. A wrong lockout state appears within two clocks, because it either blocks the first pulse or fails to stop switching when the code drops. The bench measures each run of output levels in cycles and compares it with the lengths computed from the clamp rules.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RAMP    = 3'd1,
    PH_DEAD_LO = 3'd2,
    PH_LO_ON   = 3'd3,
    PH_DEAD_HI = 3'd4,
    PH_HI_ON   = 3'd5
  } phase_t;
endpackage

// File: rtl/hbs_uvlo.sv
module hbs_uvlo #(
  parameter int SUPW      = 8,
  parameter int ON_LEVEL  = 110,
  parameter int OFF_LEVEL = 90
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SUPW-1:0] supply_code,
  output logic            power_good
);
  localparam logic [SUPW-1:0] OnLv  = SUPW'(ON_LEVEL);
  localparam logic [SUPW-1:0] OffLv = SUPW'(OFF_LEVEL);

  // Hysteresis: only a strict crossing of the active threshold changes state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      power_good <= 1'b0;
    else if (!power_good && (supply_code > OnLv))
      power_good <= 1'b1;
    else if (power_good && (supply_code < OffLv))
      power_good <= 1'b0;
  end
endmodule

// File: rtl/hbs_cfg.sv
module hbs_cfg #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] hp_in,
  input  logic [CW-1:0] dt_in,
  output logic [CW-1:0] ramp_len,
  output logic [CW-1:0] on_len,
  output logic [CW-1:0] dead_len
);
  localparam logic [CW-1:0] HpMin = CW'(2);

  logic [CW-1:0] hp_r, dt_r;
  logic [CW-1:0] hp_c, dt_c;

  // Clamp the requested values before they are captured.
  always_comb begin
    hp_c = (hp_in < HpMin) ? HpMin : hp_in;
    if (dt_in == '0)
      dt_c = CW'(1);
    else if (dt_in >= hp_c)
      dt_c = hp_c - CW'(1);
    else
      dt_c = dt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_r <= HpMin;
      dt_r <= CW'(1);
    end else if (load) begin
      hp_r <= hp_c;
      dt_r <= dt_c;
    end
  end

  assign ramp_len = hp_r >> 1;
  assign on_len   = hp_r - dt_r;
  assign dead_len = dt_r;
endmodule

// File: rtl/hbs_phase.sv
module hbs_phase
  import hbs_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] ramp_len,
  input  logic [CW-1:0] on_len,
  input  logic [CW-1:0] dead_len,
  output phase_t        phase
);
  logic [CW-1:0] cnt;
  phase_t        nxt_phase;
  logic [CW-1:0] nxt_len;

  always_comb begin
    unique case (phase)
      PH_RAMP:    nxt_phase = PH_DEAD_LO;
      PH_DEAD_LO: nxt_phase = PH_LO_ON;
      PH_LO_ON:   nxt_phase = PH_DEAD_HI;
      PH_DEAD_HI: nxt_phase = PH_HI_ON;
      PH_HI_ON:   nxt_phase = PH_DEAD_LO;
      default:    nxt_phase = PH_RAMP;
    endcase
    unique case (nxt_phase)
      PH_LO_ON, PH_HI_ON:     nxt_len = on_len;
      PH_DEAD_LO, PH_DEAD_HI: nxt_len = dead_len;
      default:                nxt_len = ramp_len;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (!run) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE || cnt == '0) begin
      phase <= nxt_phase;
      cnt   <= nxt_len - CW'(1);
    end else begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/hb_sequencer.sv
module hb_sequencer
  import hbs_pkg::*;
#(
  parameter int SUPW      = 8,
  parameter int CW        = 12,
  parameter int ON_LEVEL  = 110,
  parameter int OFF_LEVEL = 90
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SUPW-1:0] supply_code,
  input  logic            shutdown_req,
  input  logic [CW-1:0]   half_period,
  input  logic [CW-1:0]   dead_time,
  output logic            lo_gate,
  output logic            hi_gate,
  output logic            boot_en
);
  logic          pg_w;
  logic          run_w;
  logic          seq_idle;
  phase_t        phase_w;
  logic [CW-1:0] ramp_w, on_w, dead_w;

  hbs_uvlo #(.SUPW(SUPW), .ON_LEVEL(ON_LEVEL), .OFF_LEVEL(OFF_LEVEL)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .power_good(pg_w)
  );

  assign run_w    = pg_w && !shutdown_req;
  assign seq_idle = (phase_w == PH_IDLE);

  hbs_cfg #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(seq_idle),
    .hp_in(half_period), .dt_in(dead_time),
    .ramp_len(ramp_w), .on_len(on_w), .dead_len(dead_w)
  );

  hbs_phase #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run_w),
    .ramp_len(ramp_w), .on_len(on_w), .dead_len(dead_w),
    .phase(phase_w)
  );

  assign lo_gate = (phase_w == PH_LO_ON);
  assign hi_gate = (phase_w == PH_HI_ON);
  assign boot_en = (phase_w == PH_LO_ON);
endmodule

// File: rtl/hb_sequencer_sva.sv
module hb_sequencer_sva (
  input logic clk,
  input logic rst_n,
  input logic shutdown_req,
  input logic power_good,
  input logic seq_idle,
  input logic lo,
  input logic hi,
  input logic boot
);
  logic lo_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_seen <= 1'b0;
    else if (seq_idle) lo_seen <= 1'b0;
    else if (lo)     lo_seen <= 1'b1;
  end

  a_r1_lockout_low: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |=> (!lo && !hi && !boot));
  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo && hi));
  a_r5_gap_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> $past(!lo));
  a_r5_gap_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo) |-> $past(!hi));
  a_r6_boot_with_lo: assert property (@(posedge clk) disable iff (!rst_n)
    boot |-> lo);
  a_r7_shutdown_low: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> (!lo && !hi && !boot));
  a_r3_lo_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> lo_seen);
endmodule

bind hb_sequencer hb_sequencer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .shutdown_req(shutdown_req),
  .power_good(pg_w), .seq_idle(seq_idle),
  .lo(lo_gate), .hi(hi_gate), .boot(boot_en)
);

// File: tb/hb_sequencer_test.sv
module hb_sequencer_test;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    supply_code = 8'd0;
  logic          shutdown_req = 1'b0;
  logic [CW-1:0] half_period = 12'd20;
  logic [CW-1:0] dead_time = 12'd5;
  logic          lo_gate, hi_gate, boot_en;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit boot_bad = 1'b0;

  always #5 clk = ~clk;

  hb_sequencer uut (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code),
    .shutdown_req(shutdown_req), .half_period(half_period),
    .dead_time(dead_time), .lo_gate(lo_gate), .hi_gate(hi_gate),
    .boot_en(boot_en)
  );

  // {half_period, dead_time, ramp, on, dead}
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{ 20,   5,  10,  15,   5},
    '{ 16,   0,   8,  15,   1},   // R9 dt zero
    '{ 10,  30,   5,   1,   9},   // R9 dt too large
    '{  8,   8,   4,   1,   7},   // R9 dt equal to hp
    '{  1,   1,   1,   1,   1},   // R9 hp below 2
    '{500, 110, 250, 390, 110},   // R10 1.1 us
    '{500,  60, 250, 440,  60}    // R10 0.6 us
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count consecutive samples with {lo,hi} == pat, starting at the current sample.
  task automatic run_len(input logic [1:0] pat, output int n);
    n = 0;
    while ({lo_gate, hi_gate} == pat && n < 5000) begin
      if (boot_en !== lo_gate) boot_bad = 1'b1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Full cycle after start: lead gap, lo, dead, hi, dead, then lo again.
  task automatic cycle_check(input string tag, input int lead, input int on, input int dd);
    int n;
    boot_bad = 1'b0;
    run_len(2'b00, n); check(n == lead, {tag, " R3 R11 lead"}, n, lead);
    check(lo_gate == 1'b1, {tag, " R3 lo first"}, lo_gate, 1);
    run_len(2'b10, n); check(n == on, {tag, " R4 lo width"}, n, on);
    run_len(2'b00, n); check(n == dd, {tag, " R4 R5 dead"}, n, dd);
    run_len(2'b01, n); check(n == on, {tag, " R4 hi width"}, n, on);
    run_len(2'b00, n); check(n == dd, {tag, " R4 dead2"}, n, dd);
    check(lo_gate == 1'b1, {tag, " R4 repeat lo"}, lo_gate, 1);
    check(!boot_bad, {tag, " R6 boot"}, boot_bad, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(!lo_gate && !hi_gate && !boot_en, "R1 reset", {lo_gate, hi_gate, boot_en}, 0);
    rst_n = 1'b1;
    supply_code = 8'd110;              // R2 equal to on level: no start
    n = 0;
    repeat (20) begin @(negedge clk); if (lo_gate || hi_gate) n++; end
    check(n == 0, "R2 at on level", n, 0);
    supply_code = 8'd111;
    @(negedge clk);
    cycle_check("start", 1 + 10 + 5, 15, 5);
    supply_code = 8'd90;                // R2 equal to off level: keeps running
    run_len(2'b10, n); check(n == 15, "R2 at off level", n, 15);
    supply_code = 8'd89;
    @(negedge clk); @(negedge clk);
    n = 0;
    repeat (30) begin if (lo_gate || hi_gate || boot_en) n++; @(negedge clk); end
    check(n == 0, "R1 R2 lockout", n, 0);
    supply_code = 8'd100;               // between levels: stays locked out
    n = 0;
    repeat (30) begin @(negedge clk); if (lo_gate || hi_gate) n++; end
    check(n == 0, "R2 hysteresis", n, 0);
    supply_code = 8'd111;
    @(negedge clk);
    cycle_check("restart", 1 + 10 + 5, 15, 5);

    for (int v = 0; v < NV; v++) begin
      shutdown_req = 1'b1;
      half_period = CW'(VEC[v][0]);
      dead_time = CW'(VEC[v][1]);
      repeat (3) @(negedge clk);
      shutdown_req = 1'b0;
      @(negedge clk);
      cycle_check($sformatf("vec%0d", v), VEC[v][2] + VEC[v][4], VEC[v][3], VEC[v][4]);
    end

    // R8: change config while running, widths stay as captured (500/60)
    half_period = 12'd30; dead_time = 12'd3;
    run_len(2'b10, n); check(n == 440, "R8 lo width kept", n, 440);
    run_len(2'b00, n); check(n == 60, "R8 dead kept", n, 60);

    // R7: shutdown during high-side pulse
    while (!hi_gate) @(negedge clk);
    shutdown_req = 1'b1;
    @(negedge clk);
    check(!hi_gate && !lo_gate && !boot_en, "R7 shutdown", {lo_gate, hi_gate, boot_en}, 0);
    n = 0;
    repeat (20) begin @(negedge clk); if (lo_gate || hi_gate || boot_en) n++; end
    check(n == 0, "R7 held low", n, 0);
    shutdown_req = 1'b0;
    @(negedge clk);
    cycle_check("R7 R8 resume", 15 + 3, 27, 3);

    finish_run();
  end
endmodule